// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small processor that runs one instruction per clock. In that one cycle it reads the instruction at the program counter, reads the source registers, runs the ALU, makes the data memory access if the instruction has one, and writes the result back to a register. The subset is register-register add, sub, and, or and set-less-than. It also has add, and and or with an immediate operand, word load and word store, and branch-if-equal and branch-if-not-equal. A separate adder computes the branch target while the ALU does the branch compare.

The core holds its own instruction memory and its own word-addressed data memory. Both are filled through two write ports, and those ports take effect only while reset is held. After reset is released the core starts at address 0. A debug port reads any register, and the current program counter is always visible, so a host can load a program, let it run and inspect the result.

Top module: `minicore_top`

## Requirements
- R1: While reset is held the program counter reads 0 and every register reads 0. Reset is synchronous and active high.
- R2: R-format words have opcode 000000 in bits [31:26], rs in [25:21], rt in [20:16] and rd in [15:11]. They write rd with rs op rt, where funct in bits [5:0] selects the op: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed less-than giving 1 or 0.
- R3: The immediate forms write rt with rs op imm, where imm is bits [15:0]. addi (001000) sign-extends the immediate and adds. andi (001100) and ori (001101) zero-extend it.
- R4: lw (100011) writes rt with the data word at byte address rs + sign-extended imm. sw (101011) writes rt's value to that word. The memory word index is address bits [..:2].
- R5: Stores and branches leave every register unchanged.
- R6: beq (000100) is taken when rs equals rt, and bne (000101) is taken when they differ. A taken branch loads PC+4 plus the sign-extended immediate times 4, and backward offsets are allowed.
- R7: Every instruction that is not a taken branch advances the program counter by 4 on the next clock.
- R8: Register 0 reads 0 at all times, and writes to it are dropped.
- R9: The instruction and data load ports write only while reset is high. While the core runs they have no effect.
- R10: An unlisted opcode, or an R-format word with an unlisted funct, changes no register and no memory, and execution continues at PC+4.
- R11: The data memory is never asked to read and write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the load ports |
| imemLoadEn | input | 1 | Instruction load strobe |
| imemLoadIdx | input | IAW | Instruction word index to load |
| imemLoadData | input | 32 | Instruction word to load |
| dmemLoadEn | input | 1 | Data load strobe |
| dmemLoadIdx | input | DAW | Data word index to load |
| dmemLoadData | input | 32 | Data word to load |
| dbgRegSel | input | 5 | Register number for the debug read |
| dbgRegData | output | 32 | Contents of the selected register |
| dbgPc | output | 32 | Current program counter |

## Verification
The hardest situation to reach is the core ignoring a load-port write while it is running. Its effect would only show up through a later instruction that depends on the overwritten word. To reach it, the bench preloads a program that idles on no-ops before a load. In the first running cycle it strikes both load ports, one at the data word that load reads and one at the load instruction itself, and then checks that the loaded register holds the value written during reset. A backward-branch countdown loop also exercises the negative branch offset and repeated not-equal decisions, and those results appear only in the final register state.

// File: rtl/core_pkg.sv
package core_pkg;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  // Strobes from the decoder into the datapath
  typedef struct packed {
    logic    regDst;    // 1: destination is rd, 0: rt
    logic    aluSrc;    // 1: second operand is the extended immediate
    logic    memToReg;  // 1: write-back from data memory
    logic    regWrite;
    logic    memRead;
    logic    memWrite;
    logic    branch;
    logic    branchNe;  // invert the equality test
    logic    zeroExt;   // zero- instead of sign-extend the immediate
    alu_op_e aluOp;
  } ctrl_t;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ANDI  = 6'b001100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

endpackage

// File: rtl/core_control.sv
module core_control
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl       = '0;
    ctl.aluOp = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctl.regDst   = 1'b1;
        ctl.regWrite = 1'b1;
        case (funct)
          FN_ADD:  ctl.aluOp = ALU_ADD;
          FN_SUB:  ctl.aluOp = ALU_SUB;
          FN_AND:  ctl.aluOp = ALU_AND;
          FN_OR:   ctl.aluOp = ALU_OR;
          FN_SLT:  ctl.aluOp = ALU_SLT;
          default: ctl.regWrite = 1'b0;  // unlisted funct behaves as a no-op (R10)
        endcase
      end
      OP_ADDI: begin
        ctl.aluSrc   = 1'b1;
        ctl.regWrite = 1'b1;
      end
      OP_ANDI: begin
        ctl.aluSrc   = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.zeroExt  = 1'b1;
        ctl.aluOp    = ALU_AND;
      end
      OP_ORI: begin
        ctl.aluSrc   = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.zeroExt  = 1'b1;
        ctl.aluOp    = ALU_OR;
      end
      OP_LW: begin
        ctl.aluSrc   = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.memRead  = 1'b1;
        ctl.memToReg = 1'b1;
      end
      OP_SW: begin
        ctl.aluSrc   = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch = 1'b1;
        ctl.aluOp  = ALU_SUB;
      end
      OP_BNE: begin
        ctl.branch   = 1'b1;
        ctl.branchNe = 1'b1;
        ctl.aluOp    = ALU_SUB;
      end
      default: ;  // unlisted opcode: all strobes low (R10)
    endcase
  end

endmodule

// File: rtl/core_datapath.sv
module core_datapath
  import core_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  parameter  int NUM_REGS   = 32,
  localparam int IAW        = $clog2(IMEM_WORDS),
  localparam int DAW        = $clog2(DMEM_WORDS),
  localparam int RAW        = $clog2(NUM_REGS)
) (
  input  logic           clk,
  input  logic           rst,
  input  ctrl_t          ctl,
  output logic [31:0]    instr,
  input  logic           imemLoadEn,
  input  logic [IAW-1:0] imemLoadIdx,
  input  logic [31:0]    imemLoadData,
  input  logic           dmemLoadEn,
  input  logic [DAW-1:0] dmemLoadIdx,
  input  logic [31:0]    dmemLoadData,
  input  logic [RAW-1:0] dbgRegSel,
  output logic [31:0]    dbgRegData,
  output logic [31:0]    dbgPc
);

  logic [31:0] pc, pcPlus4, branchTarget, pcNext;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [NUM_REGS];

  logic [RAW-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic [31:0]    rsData, rtData, immExt, opB, aluRes, memRdata, wbData;
  logic [DAW-1:0] dataIdx;
  logic           zero, pcSel;

  // Fetch
  assign instr = imem[pc[IAW+1:2]];

  always_ff @(posedge clk) begin
    if (rst && imemLoadEn) imem[imemLoadIdx] <= imemLoadData;
  end

  // Decode and operand read
  assign rsIdx  = instr[21 +: RAW];
  assign rtIdx  = instr[16 +: RAW];
  assign rdIdx  = instr[11 +: RAW];
  assign wrIdx  = ctl.regDst ? rdIdx : rtIdx;
  assign rsData = regs[rsIdx];
  assign rtData = regs[rtIdx];
  assign immExt = ctl.zeroExt ? {16'b0, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};
  assign opB    = ctl.aluSrc ? immExt : rtData;

  // ALU
  always_comb begin
    case (ctl.aluOp)
      ALU_AND: aluRes = rsData & opB;
      ALU_OR:  aluRes = rsData | opB;
      ALU_ADD: aluRes = rsData + opB;
      ALU_SUB: aluRes = rsData - opB;
      ALU_SLT: aluRes = {31'b0, $signed(rsData) < $signed(opB)};
      default: aluRes = '0;
    endcase
  end
  assign zero = (aluRes == '0);

  // Next PC: a separate adder forms the target while the ALU compares
  assign pcPlus4      = pc + 32'd4;
  assign branchTarget = pcPlus4 + {immExt[29:0], 2'b00};
  assign pcSel        = ctl.branch && (zero != ctl.branchNe);
  assign pcNext       = pcSel ? branchTarget : pcPlus4;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end

  // Data memory
  assign dataIdx  = aluRes[DAW+1:2];
  assign memRdata = ctl.memRead ? dmem[dataIdx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (dmemLoadEn) dmem[dmemLoadIdx] <= dmemLoadData;
    end else if (ctl.memWrite) begin
      dmem[dataIdx] <= rtData;
    end
  end

  // Write-back
  assign wbData = ctl.memToReg ? memRdata : aluRes;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (ctl.regWrite && (wrIdx != '0)) begin
      regs[wrIdx] <= wbData;
    end
  end

  assign dbgRegData = regs[dbgRegSel];
  assign dbgPc      = pc;

  // Checks next to the logic they guard
  assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
    !pcSel |=> (pc == $past(pc) + 32'd4));

  assert_branch_only_R6: assert property (@(posedge clk) disable iff (rst)
    pcSel |-> ctl.branch);

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
    (dbgRegSel == '0) |-> (dbgRegData == '0));

  assert_mem_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(ctl.memRead && ctl.memWrite));

  assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl.memWrite || ctl.branch) |-> !ctl.regWrite);

  assert_pc_held_in_reset_R1: assert property (@(posedge clk)
    rst |=> (pc == '0));

endmodule

// File: rtl/minicore_top.sv
module minicore_top
  import core_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IAW        = $clog2(IMEM_WORDS),
  localparam int DAW        = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           imemLoadEn,
  input  logic [IAW-1:0] imemLoadIdx,
  input  logic [31:0]    imemLoadData,
  input  logic           dmemLoadEn,
  input  logic [DAW-1:0] dmemLoadIdx,
  input  logic [31:0]    dmemLoadData,
  input  logic [4:0]     dbgRegSel,
  output logic [31:0]    dbgRegData,
  output logic [31:0]    dbgPc
);

  ctrl_t       ctl;
  logic [31:0] instr;

  core_control u_control (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl)
  );

  core_datapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS),
    .NUM_REGS   (32)
  ) u_datapath (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .instr        (instr),
    .imemLoadEn   (imemLoadEn),
    .imemLoadIdx  (imemLoadIdx),
    .imemLoadData (imemLoadData),
    .dmemLoadEn   (dmemLoadEn),
    .dmemLoadIdx  (dmemLoadIdx),
    .dmemLoadData (dmemLoadData),
    .dbgRegSel    (dbgRegSel),
    .dbgRegData   (dbgRegData),
    .dbgPc        (dbgPc)
  );

endmodule

// File: tb/tb_minicore_top.sv
module tb_minicore_top;

  localparam int IW = 64;
  localparam int DW = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imemLoadEn = 1'b0;
  logic [5:0]  imemLoadIdx = '0;
  logic [31:0] imemLoadData = '0;
  logic        dmemLoadEn = 1'b0;
  logic [5:0]  dmemLoadIdx = '0;
  logic [31:0] dmemLoadData = '0;
  logic [4:0]  dbgRegSel = '0;
  logic [31:0] dbgRegData, dbgPc;

  minicore_top #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut (
    .clk(clk), .rst(rst),
    .imemLoadEn(imemLoadEn), .imemLoadIdx(imemLoadIdx), .imemLoadData(imemLoadData),
    .dmemLoadEn(dmemLoadEn), .dmemLoadIdx(dmemLoadIdx), .dmemLoadData(dmemLoadData),
    .dbgRegSel(dbgRegSel), .dbgRegData(dbgRegData), .dbgPc(dbgPc)
  );

  always #2 clk = ~clk;  // 4 ns period

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  logic [31:0] prog [IW];
  int          progLen;

  // Encoders written from the requirement text
  function automatic logic [31:0] encR(input logic [5:0] fn, input int rs, input int rt, input int rd);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b0, fn};
  endfunction
  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  localparam logic [31:0] HALT = 32'h1000FFFF;  // beq r0,r0,-1
  localparam logic [31:0] NOP  = 32'h00000020;  // add r0,r0,r0

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkReg(input string req, input int r, input logic [31:0] exp);
    dbgRegSel = 5'(r);
    #0.5;
    check(req, dbgRegData, exp);
  endtask

  task automatic enterReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic pokeData(input int idx, input logic [31:0] val);
    dmemLoadEn = 1'b1; dmemLoadIdx = 6'(idx); dmemLoadData = val;
    @(negedge clk);
    dmemLoadEn = 1'b0;
  endtask

  task automatic loadProg();
    for (int i = 0; i < IW; i++) begin
      imemLoadEn = 1'b1; imemLoadIdx = 6'(i);
      imemLoadData = (i < progLen) ? prog[i] : HALT;
      @(negedge clk);
    end
    imemLoadEn = 1'b0;
  endtask

  task automatic release_run(input int n);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // R2 and R7
  task automatic testArith();
    enterReset();
    prog[0] = encI(6'b001000, 0, 1, 16'd5);
    prog[1] = encI(6'b001000, 0, 2, 16'hFFFD);
    prog[2] = encR(6'b100000, 1, 2, 3);
    prog[3] = encR(6'b100010, 1, 2, 4);
    prog[4] = encR(6'b100100, 1, 2, 5);
    prog[5] = encR(6'b100101, 1, 2, 6);
    prog[6] = encR(6'b101010, 2, 1, 7);
    prog[7] = encR(6'b101010, 1, 2, 8);
    progLen = 8;
    loadProg();
    release_run(1);
    check("R7 pc after first instruction", dbgPc, 32'd4);
    repeat (20) @(negedge clk);
    checkReg("R2 add", 3, 32'd2);
    checkReg("R2 sub", 4, 32'd8);
    checkReg("R2 and", 5, 32'd5);
    checkReg("R2 or", 6, 32'hFFFFFFFD);
    checkReg("R2 slt true signed", 7, 32'd1);
    checkReg("R2 slt false", 8, 32'd0);
    check("R7 halted pc", dbgPc, 32'd32);
  endtask

  // R1: reset clears pc and registers left by the previous program
  task automatic testReset();
    enterReset();
    @(negedge clk);
    check("R1 pc in reset", dbgPc, 32'd0);
    checkReg("R1 reg cleared", 3, 32'd0);
    checkReg("R1 reg cleared", 6, 32'd0);
  endtask

  // R3
  task automatic testImm();
    enterReset();
    prog[0] = encI(6'b001000, 0, 1, 16'hFFFF);
    prog[1] = encI(6'b001100, 1, 2, 16'h8001);
    prog[2] = encI(6'b001101, 0, 3, 16'hF000);
    prog[3] = encI(6'b001000, 0, 4, 16'h8000);
    prog[4] = encI(6'b001100, 4, 6, 16'hFFFF);
    progLen = 5;
    loadProg();
    release_run(20);
    checkReg("R3 addi sign-extends", 1, 32'hFFFFFFFF);
    checkReg("R3 andi zero-extends", 2, 32'h00008001);
    checkReg("R3 ori zero-extends", 3, 32'h0000F000);
    checkReg("R3 addi negative", 4, 32'hFFFF8000);
    checkReg("R3 andi upper cleared", 6, 32'h00008000);
  endtask

  // R4, R5, R11 (a load straight after a store sees the stored word)
  task automatic testMem();
    enterReset();
    pokeData(2, 32'h12345678);
    pokeData(5, 32'hCAFEF00D);
    prog[0] = encI(6'b001000, 0, 1, 16'd4);
    prog[1] = encI(6'b100011, 1, 2, 16'd4);
    prog[2] = encI(6'b101011, 1, 2, 16'd0);
    prog[3] = encI(6'b100011, 0, 3, 16'd4);
    prog[4] = encI(6'b001000, 0, 6, 16'd24);
    prog[5] = encI(6'b100011, 6, 4, 16'hFFFC);
    progLen = 6;
    loadProg();
    release_run(20);
    checkReg("R4 lw base+offset", 2, 32'h12345678);
    checkReg("R4 R11 sw then lw", 3, 32'h12345678);
    checkReg("R4 lw negative offset", 4, 32'hCAFEF00D);
    checkReg("R5 sw leaves rt", 2, 32'h12345678);
    checkReg("R5 sw leaves rs", 1, 32'd4);
  endtask

  // R6, R5
  task automatic testBranch();
    enterReset();
    prog[0]  = encI(6'b001000, 0, 1, 16'd7);
    prog[1]  = encI(6'b001000, 0, 2, 16'd7);
    prog[2]  = encI(6'b000100, 1, 2, 16'd1);
    prog[3]  = encI(6'b001000, 0, 3, 16'd1);
    prog[4]  = encI(6'b000101, 1, 2, 16'd1);
    prog[5]  = encI(6'b001000, 0, 4, 16'd2);
    prog[6]  = encI(6'b001000, 0, 5, 16'd3);
    prog[7]  = encI(6'b001000, 5, 5, 16'hFFFF);
    prog[8]  = encI(6'b000101, 5, 0, 16'hFFFE);
    prog[9]  = encI(6'b001000, 0, 6, 16'd9);
    progLen = 10;
    loadProg();
    release_run(40);
    checkReg("R6 beq taken skips", 3, 32'd0);
    checkReg("R6 bne not taken falls through", 4, 32'd2);
    checkReg("R6 bne backward loop count", 5, 32'd0);
    checkReg("R6 after loop", 6, 32'd9);
    checkReg("R5 branch leaves rt", 2, 32'd7);
    check("R6 halt target", dbgPc, 32'd40);
  endtask

  // R8, R10
  task automatic testZeroAndIllegal();
    enterReset();
    prog[0] = encI(6'b001000, 0, 1, 16'd11);
    prog[1] = encI(6'b001000, 0, 0, 16'd5);
    prog[2] = encR(6'b100000, 0, 0, 2);
    prog[3] = encI(6'b111111, 0, 1, 16'd7);
    prog[4] = encR(6'b000001, 0, 0, 1);
    prog[5] = encI(6'b001000, 1, 3, 16'd1);
    progLen = 6;
    loadProg();
    release_run(20);
    checkReg("R8 r0 reads zero", 0, 32'd0);
    checkReg("R8 r0 sum zero", 2, 32'd0);
    checkReg("R10 bad opcode no write", 1, 32'd11);
    checkReg("R10 continues", 3, 32'd12);
    check("R10 pc flow", dbgPc, 32'd24);
  endtask

  // R9
  task automatic testLoadIgnored();
    enterReset();
    pokeData(3, 32'hAAAA0001);
    for (int i = 0; i < 8; i++) prog[i] = NOP;
    prog[8] = encI(6'b100011, 0, 1, 16'd12);
    progLen = 9;
    loadProg();
    rst = 1'b0;
    dmemLoadEn = 1'b1; dmemLoadIdx = 6'd3; dmemLoadData = 32'h55550002;
    imemLoadEn = 1'b1; imemLoadIdx = 6'd8; imemLoadData = encI(6'b001000, 0, 1, 16'd99);
    @(negedge clk);
    dmemLoadEn = 1'b0; imemLoadEn = 1'b0;
    repeat (20) @(negedge clk);
    checkReg("R9 load ports ignored while running", 1, 32'hAAAA0001);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  initial begin
    testArith();
    testReset();
    testImm();
    testMem();
    testBranch();
    testZeroAndIllegal();
    testLoadIgnored();
    finishRun();
  end

endmodule